// File: doc/BRIEF.md
# Preloadable 24-bit Interrupt Timer

This block is a down-counting event timer. The counter is 24 bits wide and is reloaded from a 24-bit preload value. It counts qualified rising edges of an external count input. That input is first brought into the core clock domain through a short synchronizer, and no prescaler is used. When the counter steps from 1 to 0, a zero-detect flag is set. What happens next is chosen by a control register: the counter either reloads from the preload value on the following count edge, or wraps to all ones.

A multi-function output pin reports timer activity in one of three ways:
- as a plain port bit under software control;
- as a square wave that toggles at every zero crossing;
- as an active-low interrupt request that stays asserted until software clears the flag.

An interrupt-acknowledge input returns an 8-bit vector, together with a bus acknowledge, but only while an interrupt request is actually pending.

A small register bus sits in front of the timer. Writes are single-cycle strobes, and reads are combinational from the address. The bus gives access to the control, preload, vector, status and port registers. The port address also reads back the live pin level. All pins are plain control and status signals and have no flow control.

Top module: `tmr_top`

## Requirements
- R1: After reset, the pin is high, the control register reads 0x00 and the status register reads 0x00.
- R2: Control bit 0 enables the timer. The timer runs when enable is 1 and clock-select bits 2:1 equal 2'b10.
  - The first qualified rising edge of count_in after the timer enters run copies the preload value into the counter.
  - Each later edge decrements it.
  - With preload P, status bit 0 (zero-detect) is set on edge P+1.
- R3: When control bit 4 is 1 (reload mode), the edge after the counter reaches 0 reloads the preload value. With preload P, zero-detect recurs every P+1 edges.
- R4: When control bit 4 is 0 (roll-over mode), the edge after 0 wraps the counter to 0xFFFFFF, so no second zero occurs soon after.
- R5: Writing 1 to status bit 0 clears zero-detect. Writing 0 leaves it unchanged.
- R6: In interrupt mode (control bits 7:5 = 3'b101), the pin is low exactly while zero-detect is set.
- R7: In square-wave mode (control bits 7:5 = 3'b010), the pin toggles at each 1-to-0 step. It is high while the timer is disabled.
- R8: In port mode (control bits 7:5 = any other code), the pin follows bit 0 of the port register (address 6, reset value 1). Reading address 6 returns the pin level in bit 0.
- R9: While ack_in is high, vec_ack is 1 and vec_data equals the vector register (address 4) only in interrupt mode with zero-detect set. Otherwise vec_ack is 0 and vec_data is 0x00.
- R10: While enable is 0, or clock-select is not 2'b10, count_in edges change neither the counter nor zero-detect.
- R11: The register map is as follows. Preload bits 23:0 are read and written with the high byte first.

| Address | Register |
|---|---|
| 0 | control |
| 1 | preload bits 23:16 |
| 2 | preload bits 15:8 |
| 3 | preload bits 7:0 |
| 4 | vector |
| 5 | status |
| 6 | port |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| count_in | input | 1 | External count input, asynchronous |
| ack_in | input | 1 | Interrupt acknowledge |
| vec_ack | output | 1 | Bus acknowledge for the vector |
| vec_data | output | 8 | Vector returned on acknowledge |
| pin_out | output | 1 | Multi-function output pin |

## Verification
The bench uses the default parameters: a 24-bit counter and a two-stage input synchronizer. Small preload values (1 to 5) bring the 1-to-0 step, the reload edge and a second zero crossing within a handful of count edges. With the full 24-bit width, a wrap in roll-over mode lands on 0xFFFFFF, which keeps any further zero out of reach and so separates it clearly from a reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] A_CTRL    = 3'd0;
  localparam logic [2:0] A_PRE_HI  = 3'd1;
  localparam logic [2:0] A_VEC     = 3'd4;
  localparam logic [2:0] A_STAT    = 3'd5;
  localparam logic [2:0] A_PORT    = 3'd6;

  localparam logic [2:0] MODE_SQUARE = 3'b010;
  localparam logic [2:0] MODE_IRQ    = 3'b101;

  localparam logic [1:0] CLKSEL_EXT  = 2'b10;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  input  logic             zero_evt,
  input  logic             pin_level,
  output logic             enable,
  output logic [2:0]       mode,
  output logic             reload_mode,
  output logic [1:0]       clk_sel,
  output logic [CNT_W-1:0] preload,
  output logic [7:0]       vector,
  output logic             zd,
  output logic             port_bit,
  output logic [7:0]       rdata
);
  localparam int NB = CNT_W / 8;

  logic [7:0] ctrl_q;
  logic [7:0] pre_b [NB];
  logic       zd_q;
  logic       port_q;
  logic [7:0] vec_q;

  // Preload bytes: byte index 0 is the least significant, highest byte at A_PRE_HI
  for (genvar b = 0; b < NB; b++) begin : g_pre
    localparam logic [2:0] MY_ADDR = A_PRE_HI + 3'(NB - 1 - b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_b[b] <= '0;
      else if (wr_en && addr == MY_ADDR) pre_b[b] <= wdata;
    end
    assign preload[b*8 +: 8] = pre_b[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      vec_q  <= '0;
      port_q <= 1'b1;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl_q <= wdata;
      if (addr == A_VEC)  vec_q  <= wdata;
      if (addr == A_PORT) port_q <= wdata[0];
    end
  end

  // zero-detect: a new event wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       zd_q <= 1'b0;
    else if (zero_evt)                                zd_q <= 1'b1;
    else if (wr_en && addr == A_STAT && wdata[0])     zd_q <= 1'b0;
  end

  assign enable      = ctrl_q[0];
  assign clk_sel     = ctrl_q[2:1];
  assign reload_mode = ctrl_q[4];
  assign mode        = ctrl_q[7:5];
  assign vector      = vec_q;
  assign zd          = zd_q;
  assign port_bit    = port_q;

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)      rdata = ctrl_q;
    else if (addr == A_VEC)  rdata = vec_q;
    else if (addr == A_STAT) rdata = {7'b0, zd_q};
    else if (addr == A_PORT) rdata = {7'b0, pin_level};
    else begin
      for (int b = 0; b < NB; b++)
        if (addr == A_PRE_HI + 3'(NB - 1 - b)) rdata = pre_b[b];
    end
  end

  // R5
  zd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> zd_q);
  // R5
  zd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zd_q && !zero_evt && !(wr_en && addr == A_STAT && wdata[0])) |=> zd_q);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_in,
  input  logic             run,
  input  logic             reload_mode,
  input  logic [CNT_W-1:0] preload,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SYNC_STAGES:0] sync_q;
  logic                 edge_p;
  logic [CNT_W-1:0]     cnt_q;
  logic                 first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], count_in};
  end

  assign edge_p = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (!run) begin
      first_q <= 1'b1;
    end else if (edge_p) begin
      if (first_q) begin
        cnt_q   <= preload;
        first_q <= 1'b0;
      end else if (cnt_q == '0) begin
        cnt_q <= reload_mode ? preload : '1;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign zero_evt = run & edge_p & ~first_q & (cnt_q == ONE);

  // R2
  zero_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (cnt_q == '0));
  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));
  // R4
  roll_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && edge_p && !first_q && cnt_q == '0 && !reload_mode) |=> (cnt_q == '1));
endmodule

// File: rtl/tmr_outpin.sv
module tmr_outpin
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       enable,
  input  logic       zd,
  input  logic       zero_evt,
  input  logic       port_bit,
  input  logic       ack_in,
  input  logic [7:0] vector,
  output logic       pin_out,
  output logic       vec_ack,
  output logic [7:0] vec_data
);
  logic sq_q;
  logic is_sq;
  logic is_irq;

  assign is_sq  = (mode == MODE_SQUARE);
  assign is_irq = (mode == MODE_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sq_q <= 1'b1;
    else if (!enable)           sq_q <= 1'b1;
    else if (zero_evt && is_sq) sq_q <= ~sq_q;
  end

  always_comb begin
    if (is_irq)     pin_out = ~zd;
    else if (is_sq) pin_out = sq_q;
    else            pin_out = port_bit;
  end

  assign vec_ack  = ack_in & is_irq & zd;
  assign vec_data = vec_ack ? vector : 8'h00;

  // R9
  ack_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |-> !pin_out);
  // R7
  sq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sq && enable && zero_evt) |=> (!is_sq || pin_out != $past(pin_out)));
  // R7
  sq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sq && !enable) |=> (!is_sq || pin_out));
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       count_in,
  input  logic       ack_in,
  output logic       vec_ack,
  output logic [7:0] vec_data,
  output logic       pin_out
);
  logic             enable;
  logic [2:0]       mode;
  logic             reload_mode;
  logic [1:0]       clk_sel;
  logic [CNT_W-1:0] preload;
  logic [7:0]       vector;
  logic             zd;
  logic             port_bit;
  logic             zero_evt;
  logic             run;

  assign run = enable & (clk_sel == CLKSEL_EXT);

  tmr_regs #(.CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .zero_evt(zero_evt), .pin_level(pin_out), .enable(enable), .mode(mode),
    .reload_mode(reload_mode), .clk_sel(clk_sel), .preload(preload),
    .vector(vector), .zd(zd), .port_bit(port_bit), .rdata(bus_rdata)
  );

  tmr_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_cnt (
    .clk(clk), .rst_n(rst_n), .count_in(count_in), .run(run),
    .reload_mode(reload_mode), .preload(preload), .zero_evt(zero_evt)
  );

  tmr_outpin i_pin (
    .clk(clk), .rst_n(rst_n), .mode(mode), .enable(enable), .zd(zd),
    .zero_evt(zero_evt), .port_bit(port_bit), .ack_in(ack_in), .vector(vector),
    .pin_out(pin_out), .vec_ack(vec_ack), .vec_data(vec_data)
  );

  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IRQ) |-> (pin_out == !zd));
endmodule

// File: tb/test_tmr_top.sv
module test_tmr_top;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       count_in = 1'b0;
  logic       ack_in = 1'b0;
  logic       vec_ack;
  logic [7:0] vec_data;
  logic       pin_out;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  tmr_top i_tmr_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_in(count_in),
    .ack_in(ack_in), .vec_ack(vec_ack), .vec_data(vec_data), .pin_out(pin_out)
  );

  // {preload[23:0], ctrl[7:0], edges[7:0], exp_zd, exp_pin}
  localparam int NV = 9;
  localparam logic [41:0] VECS [NV] = '{
    {24'd3, 8'hB5, 8'd3, 1'b0, 1'b1},  // R2 one edge short of zero, irq
    {24'd3, 8'hB5, 8'd4, 1'b1, 1'b0},  // R2 R6 zero reached, irq low
    {24'd3, 8'h55, 8'd4, 1'b1, 1'b0},  // R7 square toggled once
    {24'd3, 8'h55, 8'd8, 1'b1, 1'b1},  // R3 R7 reload then second zero
    {24'd1, 8'hB5, 8'd2, 1'b1, 1'b0},  // R2 minimum preload
    {24'd2, 8'h15, 8'd3, 1'b1, 1'b1},  // R8 port mode ignores zero
    {24'd2, 8'h45, 8'd3, 1'b1, 1'b0},  // R7 square, roll-over first zero
    {24'd1, 8'hB1, 8'd5, 1'b0, 1'b1},  // R10 wrong clock select
    {24'd5, 8'hB5, 8'd6, 1'b1, 1'b0}   // R2 larger preload
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); count_in = 1'b1;
      repeat (4) @(negedge clk);
      count_in = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic setup(input logic [23:0] p, input logic [7:0] c);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h01);
    wr(3'd1, p[23:16]);
    wr(3'd2, p[15:8]);
    wr(3'd3, p[7:0]);
    wr(3'd0, c);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin", 32'(pin_out), 32'd1);
    rd(3'd0, d); check("R1 ctrl", 32'(d), 32'h00);
    rd(3'd5, d); check("R1 status", 32'(d), 32'h00);

    // R11 preload readback, high byte first
    wr(3'd1, 8'hA1); wr(3'd2, 8'hB2); wr(3'd3, 8'hC3);
    rd(3'd1, d); check("R11 pre hi", 32'(d), 32'hA1);
    rd(3'd3, d); check("R11 pre lo", 32'(d), 32'hC3);

    for (int v = 0; v < NV; v++) begin
      setup(VECS[v][41:18], VECS[v][17:10]);
      pulses(int'(VECS[v][9:2]));
      rd(3'd5, d); check($sformatf("R2 vec%0d zd", v), 32'(d[0]), 32'(VECS[v][1]));
      check($sformatf("R6 R7 R8 vec%0d pin", v), 32'(pin_out), 32'(VECS[v][0]));
      rd(3'd6, d); check($sformatf("R8 vec%0d readback", v), 32'(d[0]), 32'(VECS[v][0]));
    end

    // R9 acknowledge with pending interrupt
    wr(3'd4, 8'h5A);
    setup(24'd1, 8'hB5);
    pulses(2);
    @(negedge clk); ack_in = 1'b1; #1;
    check("R9 ack pending", 32'(vec_ack), 32'd1);
    check("R9 vector", 32'(vec_data), 32'h5A);
    ack_in = 1'b0;
    // R5 writing 0 does not clear
    wr(3'd5, 8'h00);
    rd(3'd5, d); check("R5 write0 keeps", 32'(d), 32'h01);
    wr(3'd5, 8'h01);
    rd(3'd5, d); check("R5 write1 clears", 32'(d), 32'h00);
    check("R6 pin released", 32'(pin_out), 32'd1);
    @(negedge clk); ack_in = 1'b1; #1;
    check("R9 no pending", 32'(vec_ack), 32'd0);
    check("R9 no data", 32'(vec_data), 32'h00);
    ack_in = 1'b0;

    // R9 square mode with flag set: no response
    setup(24'd1, 8'h55);
    pulses(2);
    @(negedge clk); ack_in = 1'b1; #1;
    check("R9 square no ack", 32'(vec_ack), 32'd0);
    ack_in = 1'b0;

    // R3 reload vs R4 roll-over after first zero
    setup(24'd1, 8'hB5);
    pulses(2); wr(3'd5, 8'h01); pulses(2);
    rd(3'd5, d); check("R3 second zero", 32'(d), 32'h01);
    setup(24'd1, 8'hA5);
    pulses(2); wr(3'd5, 8'h01); pulses(2);
    rd(3'd5, d); check("R4 wrap no zero", 32'(d), 32'h00);

    // R10 disabled timer ignores edges
    setup(24'd3, 8'hB5);
    pulses(2);
    wr(3'd0, 8'hB4);
    pulses(5);
    rd(3'd5, d); check("R10 halted", 32'(d), 32'h00);

    // R7 disabled square mode idles high
    wr(3'd0, 8'h44);
    @(negedge clk); check("R7 idle high", 32'(pin_out), 32'd1);

    // R8 port bit drive and readback
    wr(3'd0, 8'h00);
    wr(3'd6, 8'h00);
    @(negedge clk); check("R8 port low", 32'(pin_out), 32'd0);
    rd(3'd6, d); check("R8 readback low", 32'(d), 32'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule